// File: doc/BRIEF.md
# Lock-Loss Status Group with Edge-Filtered Event Latch

This block gathers lock-loss flags from the frequency section of an instrument into a 16-bit status group. Each flag is 1 while its loop or reference is unlocked and 0 while it is locked. The flags pass through a two-flop synchronizer and land in a condition register. Software can read that register but cannot write it.

Two per-bit filter masks decide which changes of a condition bit are recorded. One mask catches the moment a loop loses lock (0 to 1). The other catches the moment it regains lock (1 to 0). A bit may be armed in either mask, in both, or in neither. Recorded changes accumulate in a sticky event register. Reading that register returns its contents and empties it in the same access.

An enable mask picks which event bits drive a single summary output. A higher level of status reporting can use that output as its flag.

The group has five registers on a small register bus:

| Address | Register | Access |
|---|---|---|
| 0 | condition | read only |
| 1 | rising filter | read/write |
| 2 | falling filter | read/write |
| 3 | event | read, cleared by the read |
| 4 | summary enable | read/write |

The condition bits are assigned as follows:

| Bit | Meaning |
|---|---|
| 0 | synthesizer unlocked |
| 1 | 10 MHz reference unlocked |
| 2 | 1 GHz reference unlocked |
| 3 | baseband generator unlocked |
| 5 | sampler loop unlocked |
| 6 | YIG-oscillator loop unlocked |
| 4 and 7 to 15 | unused, always 0 |

Top module: `lock_status_group`

## Requirements
- R1: Reading address 0 returns the status inputs delayed by two clock edges and masked to the used bits (bits 0, 1, 2, 3, 5 and 6, mask 0x006F). Bits 4 and 7 to 15 read as 0 whatever the inputs are.
- R2: A bus write to address 0 has no effect on the condition value that is read back.
- R3: When a condition bit goes from 0 to 1 and the same bit is set in the rising filter (address 1), that event bit is set on the clock edge after the change shows in the condition register.
- R4: When a condition bit goes from 1 to 0 and the same bit is set in the falling filter (address 2), that event bit is set on the same clock edge as in R3.
- R5: A change of a condition bit whose direction is not enabled for that bit leaves the event bit unchanged. A bit armed in both filters records both directions.
- R6: Event bits stay set until the event register (address 3) is read. The read returns the accumulated value, and from the next cycle the register holds 0.
- R7: An event that is set on the same clock edge as an event-register read is kept and shows in the following read. The read itself returns the value from before that edge.
- R8: `summary_o` is 1 exactly when some event bit is set whose bit is also set in the enable register (address 4).
- R9: After reset, the rising filter reads 0x006F, and the falling filter, the enable register and the event register read 0. A filter or enable write keeps only the used bits, so writing 0xFFFF reads back as 0x006F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| status_in | input | 16 | Asynchronous lock-loss flags; 1 means unlocked |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 3 clears the event register |
| addr | input | 3 | Register address (0 to 4) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid combinationally while `rd_en` is high |
| summary_o | output | 1 | OR of the event bits gated by the enable register |

## Verification
The bench builds the block with its default parameters: a 16-bit group, used-bit mask 0x006F and a two-stage synchronizer. Because the mask leaves bit 4 and bits 7 to 15 unused, driving every input high shows directly that the dead positions read back as zero in both the condition and the filter registers.

The two-stage synchronizer fixes the latency from input to event at three edges. That fixed latency lets the bench place a new transition exactly on the edge where an event read clears the register.

// File: rtl/lock_status_group.sv
module lock_status_group #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] USED_MASK = 16'h006F,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              summary_o
);
  localparam logic [ADDR_W-1:0] A_COND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(4);

  logic [DATA_W-1:0] sync_q [SYNC_STAGES];
  logic [DATA_W-1:0] cond, prev_q, rise_q, fall_q, en_q, evt_q, hit;
  logic rd_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= status_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign cond   = sync_q[SYNC_STAGES-1] & USED_MASK;
  assign hit    = (cond & ~prev_q & rise_q) | (~cond & prev_q & fall_q);
  assign rd_evt = rd_en && (addr == A_EVT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      rise_q <= USED_MASK;
      fall_q <= '0;
      en_q   <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= cond;
      evt_q  <= rd_evt ? hit : (evt_q | hit);
      if (wr_en) begin
        case (addr)
          A_RISE:  rise_q <= wdata & USED_MASK;
          A_FALL:  fall_q <= wdata & USED_MASK;
          A_EN:    en_q   <= wdata & USED_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_COND:  rdata = cond;
      A_RISE:  rdata = rise_q;
      A_FALL:  rdata = fall_q;
      A_EVT:   rdata = evt_q;
      A_EN:    rdata = en_q;
      default: rdata = '0;
    endcase
  end

  assign summary_o = |(evt_q & en_q);

  logic [3:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q < 4'(SYNC_STAGES)) warm_q <= warm_q + 4'd1;
  end

  assert_cond_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 4'(SYNC_STAGES)) |-> cond == $past(status_in & USED_MASK, SYNC_STAGES));

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cond & ~prev_q & rise_q)) |=>
      ((evt_q & $past(cond & ~prev_q & rise_q)) == $past(cond & ~prev_q & rise_q)));

  assert_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~cond & prev_q & fall_q)) |=>
      ((evt_q & $past(~cond & prev_q & fall_q)) == $past(~cond & prev_q & fall_q)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && hit == '0) |=> evt_q == '0);

  assert_summary_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q == '0) |-> !summary_o);
endmodule

// File: tb/lock_status_group_test.sv
module lock_status_group_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] status_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        summary_o;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  lock_status_group uut (
    .clk(clk), .rst_n(rst_n), .status_in(status_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .summary_o(summary_o)
  );

  always @(negedge clk) begin
    if (rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s addr %0d: actual %h expected %h", t, addr, rdata, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    step(1);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic chk_sum(input logic e, input string t);
    checks++;
    if (summary_o !== e) begin
      errors++;
      $display("FAIL %s summary: actual %b expected %b", t, summary_o, e);
    end
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R9 reset values
    rd(3'd0, 16'h0000, "R9");
    rd(3'd1, 16'h006F, "R9");
    rd(3'd2, 16'h0000, "R9");
    rd(3'd3, 16'h0000, "R9");
    rd(3'd4, 16'h0000, "R9");
    chk_sum(1'b0, "R9");
    // R1 masking, R3 rising with default filter
    status_in = 16'hFFFF; step(4);
    rd(3'd0, 16'h006F, "R1");
    rd(3'd3, 16'h006F, "R3");
    rd(3'd3, 16'h0000, "R6");
    // R2 condition not writable
    wr(3'd0, 16'h0000);
    rd(3'd0, 16'h006F, "R2");
    // R9 filter masking, R4 falling
    wr(3'd2, 16'hFFFF);
    rd(3'd2, 16'h006F, "R9");
    status_in = 16'h0000; step(4);
    rd(3'd0, 16'h0000, "R1");
    rd(3'd3, 16'h006F, "R4");
    // R5 unarmed directions, R6 accumulation
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0020);
    status_in = 16'h0021; step(4);
    status_in = 16'h0000; step(4);
    rd(3'd3, 16'h0021, "R5");
    rd(3'd3, 16'h0000, "R6");
    // R5 both directions on one bit
    wr(3'd1, 16'h0004);
    wr(3'd2, 16'h0004);
    status_in = 16'h0004; step(4);
    rd(3'd3, 16'h0004, "R5");
    status_in = 16'h0000; step(4);
    rd(3'd3, 16'h0004, "R5");
    // R8 summary gating
    wr(3'd1, 16'h0008);
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h0002);
    status_in = 16'h0008; step(4);
    chk_sum(1'b0, "R8");
    wr(3'd4, 16'h0008);
    chk_sum(1'b1, "R8");
    rd(3'd3, 16'h0008, "R8");
    chk_sum(1'b0, "R8");
    // R7 event on the same edge as the clearing read
    wr(3'd1, 16'h0040);
    status_in = 16'h0048;
    step(2);
    rd(3'd3, 16'h0000, "R7");
    rd(3'd3, 16'h0040, "R7");
    rd(3'd3, 16'h0000, "R7");
    step(2);
    finish_run();
  end
endmodule